// File: doc/BRIEF.md
# Receive Ring Frame Extractor

This engine empties a circular receive ring held in a byte-addressed packet memory that has a synchronous read port. A start pulse begins a walk from a saved read position. For each pending frame the engine fetches a six-byte header at that position, decides whether the frame is usable, and sends the usable payload bytes out as a stream. Each stream byte carries valid, start-of-frame and end-of-frame flags and waits on a ready input.

After each frame, kept or discarded, the engine moves its read position to the frame's next pointer. It publishes a freed-space pointer for the receiver and sends one decrement strobe to the external pending-frame counter. It then reads that counter again and continues until the count reaches zero. It never relies on an interrupt flag.

Ring bounds, the transmit-area start and the largest accepted byte count are parameters. The ring start value is also the read position after reset.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset `out_valid`, `dec_strobe` and `rx_reset_req` are low, `busy` is low, and `rdptr` equals the ring end.
- R2: A `start` pulse seen while `pend_cnt` is nonzero begins a walk at the saved read position. A `start` pulse seen while `pend_cnt` is zero produces no strobe, no read and no output.
- R3: Header byte 0 is the next pointer low byte and byte 1 is its high byte. Bytes 2 and 3 are the byte count, low byte first. Byte 4 is the status low byte, and byte 5 is ignored. A kept frame's payload follows the header and is streamed in memory order, `out_sof` on the first byte and `out_eof` on the last.
- R4: A frame whose status bit 7 is 0 is discarded.
- R5: A frame whose byte count is 0 or greater than `MAX_LEN` is discarded.
- R6: A frame whose 16-bit next pointer is greater than or equal to `TX_START` is discarded.
- R7: A discarded frame sends no stream bytes and pulses `rx_reset_req` for one cycle. `dec_strobe` follows in the next cycle.
- R8: Every frame, kept or discarded, yields exactly one single-cycle `dec_strobe`. The walk continues while `pend_cnt` is nonzero after the strobe.
- R9: `rdptr` changes only together with `dec_strobe`, and then becomes next pointer minus 1. If that value lies below the ring start or above the ring end, `rdptr` becomes the ring end.
- R10: Memory reads step from the ring end address to the ring start address, so header and payload wrap around the ring.
- R11: While `out_valid` is high and `out_ready` is low, the byte and its flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk |
| pend_cnt | input | CW | Pending-frame count from the external counter |
| dec_strobe | output | 1 | One-cycle decrement request to the counter |
| mem_rd | output | 1 | Memory read enable |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| rdptr | output | AW | Freed-space pointer for the receiver |
| rx_reset_req | output | 1 | One-cycle pulse on a discarded frame |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_ready | input | 1 | Stream consumer ready |
| busy | output | 1 | Walk in progress |

## Verification
The read-address check assumes that every next pointer lying in a header that is followed by further reads falls inside the ring. The stimulus therefore places an out-of-ring next pointer only in the final frame of the run, which issues no reads after it. The pending counter is modelled so that it updates on the same edge as `dec_strobe`, and the engine samples it one cycle later. Start pulses are applied only after the counter has been loaded. Backpressure is created by holding ready low and then toggling it every cycle, which exercises the hold rule on every stalled byte.

// File: rtl/rx_ring_walker.sv
module rx_ring_walker #(
  parameter int AW         = 13,
  parameter int CW         = 8,
  parameter int RING_START = 0,
  parameter int RING_END   = 6655,
  parameter int TX_START   = 6656,
  parameter int MAX_LEN    = 1518
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] pend_cnt,
  output logic          dec_strobe,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] rdptr,
  output logic          rx_reset_req,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eof,
  input  logic          out_ready,
  output logic          busy
);
  localparam logic [AW-1:0] RS = RING_START[AW-1:0];
  localparam logic [AW-1:0] RE = RING_END[AW-1:0];

  typedef enum logic [3:0] {
    S_IDLE, S_HREQ, S_HCAP, S_CHECK, S_DREQ, S_DCAP, S_DOUT, S_FREE, S_SETTLE
  } st_t;

  st_t           st;
  logic [AW-1:0] ptr;
  logic [2:0]    idx;
  logic [7:0]    nlo, nhi, llo, lhi, byte_q;
  logic          ok_bit;
  logic [15:0]   cnt;

  wire [15:0]   nxt16 = {nhi, nlo};
  wire [15:0]   len   = {lhi, llo};
  wire [AW-1:0] nxt   = nxt16[AW-1:0];
  wire [AW-1:0] dm1   = nxt - AW'(1);
  wire          keep  = ok_bit && (len != 16'd0) && (len <= 16'(MAX_LEN)) &&
                        (nxt16 < 16'(TX_START));
  wire [AW-1:0] ptr_inc = (ptr == RE) ? RS : ptr + AW'(1);

  assign mem_rd       = (st == S_HREQ) || (st == S_DREQ);
  assign mem_addr     = ptr;
  assign out_valid    = (st == S_DOUT);
  assign out_data     = byte_q;
  assign out_sof      = out_valid && (cnt == len);
  assign out_eof      = out_valid && (cnt == 16'd1);
  assign dec_strobe   = (st == S_FREE);
  assign rx_reset_req = (st == S_CHECK) && !keep;
  assign busy         = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= RS;
      rdptr  <= RE;
      idx    <= '0;
      nlo    <= '0;
      nhi    <= '0;
      llo    <= '0;
      lhi    <= '0;
      ok_bit <= 1'b0;
      cnt    <= '0;
      byte_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (start && pend_cnt != '0) st <= S_HREQ;
        end
        S_HREQ: st <= S_HCAP;
        S_HCAP: begin
          case (idx)
            3'd0: nlo <= mem_rdata;
            3'd1: nhi <= mem_rdata;
            3'd2: llo <= mem_rdata;
            3'd3: lhi <= mem_rdata;
            3'd4: ok_bit <= mem_rdata[7];
            default: ;
          endcase
          ptr <= ptr_inc;
          idx <= idx + 3'd1;
          st  <= (idx == 3'd5) ? S_CHECK : S_HREQ;
        end
        S_CHECK: begin
          cnt <= len;
          st  <= keep ? S_DREQ : S_FREE;
        end
        S_DREQ: st <= S_DCAP;
        S_DCAP: begin
          byte_q <= mem_rdata;
          st     <= S_DOUT;
        end
        S_DOUT: if (out_ready) begin
          ptr <= ptr_inc;
          cnt <= cnt - 16'd1;
          st  <= (cnt == 16'd1) ? S_FREE : S_DREQ;
        end
        S_FREE: begin
          ptr   <= nxt;
          rdptr <= (dm1 < RS || dm1 > RE) ? RE : dm1;
          st    <= S_SETTLE;
        end
        S_SETTLE: begin
          idx <= '0;
          st  <= (pend_cnt != '0) ? S_HREQ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_ring_walker_chk #(
  parameter int AW         = 13,
  parameter int RING_START = 0,
  parameter int RING_END   = 6655
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_strobe,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] rdptr,
  input logic          rx_reset_req,
  input logic [7:0]    out_data,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eof,
  input logic          out_ready
);
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R11
  AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_strobe |=> !dec_strobe); // R8
  AST_DROP_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_req |=> dec_strobe && !out_valid); // R7
  AST_RDPTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rdptr) >= RING_START) && (int'(rdptr) <= RING_END)); // R9
  AST_RDPTR_ON_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_strobe |=> $stable(rdptr)); // R9
  AST_READ_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (int'(mem_addr) >= RING_START) && (int'(mem_addr) <= RING_END)); // R10
endmodule

bind rx_ring_walker rx_ring_walker_chk #(.AW(AW), .RING_START(RING_START), .RING_END(RING_END)) u_chk (.*);

// File: tb/test_rx_ring_walker.sv
module test_rx_ring_walker;
  localparam int AW = 8, CW = 8, RS = 16, RE = 159, TXS = 160, MAXL = 64;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] pend = '0, load_val = '0;
  logic load = 0;
  logic dec_strobe, mem_rd, rx_reset_req, out_valid, out_sof, out_eof, out_ready, busy;
  logic [AW-1:0] mem_addr, rdptr;
  logic [7:0] mem_rdata = '0, out_data;
  logic bp = 0, tog = 0, rdy_base = 1;
  logic [7:0] mem [0:255];

  int checks = 0, fails = 0;
  int n_dec, n_rst, n_got, n_exp;
  logic [7:0] got_d [0:255];
  logic got_s [0:255], got_e [0:255];
  logic [7:0] exp_d [0:255];
  logic exp_s [0:255], exp_e [0:255];

  always #4 clk = ~clk;
  assign out_ready = bp ? tog : rdy_base;

  rx_ring_walker #(.AW(AW), .CW(CW), .RING_START(RS), .RING_END(RE),
                   .TX_START(TXS), .MAX_LEN(MAXL)) i_rx_ring_walker (
    .clk, .rst_n, .start, .pend_cnt(pend), .dec_strobe, .mem_rd, .mem_addr,
    .mem_rdata, .rdptr, .rx_reset_req, .out_data, .out_valid, .out_sof,
    .out_eof, .out_ready, .busy);

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];
  always @(posedge clk) if (load) pend <= load_val; else if (dec_strobe) pend <= pend - 1'b1;
  always @(negedge clk) tog <= ~tog;

  always @(posedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      got_d[n_got] = out_data; got_s[n_got] = out_sof; got_e[n_got] = out_eof; n_got++;
    end
    if (dec_strobe) n_dec++;
    if (rx_reset_req) n_rst++;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wr(int a);
    return (a > RE) ? a - (RE - RS + 1) : a;
  endfunction

  task automatic clear();
    n_dec = 0; n_rst = 0; n_got = 0; n_exp = 0;
  endtask

  task automatic put_frame(int at, int nxt, int len, int stat, int seed, bit kept);
    mem[wr(at)] = nxt[7:0]; mem[wr(at+1)] = nxt[15:8];
    mem[wr(at+2)] = len[7:0]; mem[wr(at+3)] = len[15:8];
    mem[wr(at+4)] = stat[7:0]; mem[wr(at+5)] = 8'h5A;
    for (int i = 0; i < len && i < 80; i++) begin
      mem[wr(at+6+i)] = 8'(seed + i);
      if (kept) begin
        exp_d[n_exp] = 8'(seed + i); exp_s[n_exp] = (i == 0); exp_e[n_exp] = (i == len-1); n_exp++;
      end
    end
  endtask

  task automatic kick(int n);
    @(negedge clk); load = 1; load_val = 8'(n);
    @(negedge clk); load = 0; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(!busy, "R8 walk ends", busy, 0);
  endtask

  task automatic cmp_stream(string req);
    bit ok = (n_got == n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      if (got_d[i] != exp_d[i] || got_s[i] != exp_s[i] || got_e[i] != exp_e[i]) ok = 0;
    chk(ok, req, n_got, n_exp);
  endtask

  task automatic t_reset();
    chk(!out_valid && !dec_strobe && !rx_reset_req && !busy, "R1 idle outputs", out_valid, 0);
    chk(rdptr == RE, "R1 rdptr", rdptr, RE);
  endtask

  task automatic t_single();
    clear(); put_frame(16, 26, 4, 8'h80, 8'h30, 1);
    kick(1); wait_done();
    cmp_stream("R3 single frame");
    chk(n_dec == 1 && pend == 0, "R8 one decrement", n_dec, 1);
    chk(rdptr == 25, "R9 rdptr", rdptr, 25);
    chk(n_rst == 0, "R7 no reset on good", n_rst, 0);
  endtask

  task automatic t_two_bp();
    logic [7:0] d0;
    int t = 0;
    clear(); put_frame(26, 37, 5, 8'h81, 8'h40, 1); put_frame(37, 46, 3, 8'hFF, 8'h70, 1);
    rdy_base = 0;
    kick(2);
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    d0 = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid && out_sof && out_data == d0, "R11 hold on stall", out_data, d0);
    bp = 1; wait_done(); bp = 0; rdy_base = 1;
    cmp_stream("R11 stream under backpressure");
    chk(n_dec == 2, "R8 two frames", n_dec, 2);
    chk(rdptr == 45, "R9 rdptr", rdptr, 45);
  endtask

  task automatic t_status();
    clear(); put_frame(46, 55, 3, 8'h7F, 8'h11, 0);
    kick(1); wait_done();
    chk(n_got == 0, "R4 no bytes", n_got, 0);
    chk(n_rst == 1, "R7 reset req", n_rst, 1);
    chk(n_dec == 1 && rdptr == 54, "R4 freed", rdptr, 54);
  endtask

  task automatic t_len();
    clear(); put_frame(55, 61, 0, 8'h80, 8'h00, 0); put_frame(61, 132, 65, 8'h80, 8'h20, 0);
    kick(2); wait_done();
    chk(n_got == 0, "R5 no bytes", n_got, 0);
    chk(n_rst == 2 && n_dec == 2, "R5 two drops", n_rst, 2);
    chk(rdptr == 131, "R5 rdptr", rdptr, 131);
  endtask

  task automatic t_zero_pend();
    clear(); kick(0);
    repeat (5) @(negedge clk);
    chk(n_dec == 0 && n_got == 0 && !busy, "R2 zero pending", n_dec, 0);
    chk(rdptr == 131, "R2 rdptr unchanged", rdptr, 131);
  endtask

  task automatic t_wrap();
    clear(); put_frame(132, 152, 2, 8'h80, 8'h90, 1); put_frame(152, 24, 10, 8'h80, 8'hA0, 1);
    kick(2); wait_done();
    cmp_stream("R10 wrapped frame");
    chk(rdptr == 23, "R10 rdptr after wrap", rdptr, 23);
  endtask

  task automatic t_clamp();
    clear(); put_frame(24, 16, 2, 8'h80, 8'hC0, 1);
    kick(1); wait_done();
    cmp_stream("R9 clamp frame");
    chk(rdptr == RE, "R9 clamp to ring end", rdptr, RE);
  endtask

  task automatic t_tx();
    clear(); put_frame(16, 160, 2, 8'h80, 8'hD0, 0);
    kick(1); wait_done();
    chk(n_got == 0 && n_rst == 1, "R6 tx-area pointer dropped", n_got, 0);
    chk(n_dec == 1, "R6 decrement", n_dec, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_two_bp();
    t_status();
    t_len();
    t_zero_pend();
    t_wrap();
    t_clamp();
    t_tx();
    summary();
  end
endmodule